// File: doc/BRIEF.md
# Request Size to Burst Translator

This block turns the size information of an incoming memory request into the burst parameters of a memory-mapped master port. The data path is 128 bits wide with 16 byte lanes. A request names a direction (read or write), a 4-bit size code, a word-pointer bit and a doubleword select (address bit 0). A write also gives its payload length in 8-byte doublewords. From these the block derives a burst count and a byte-enable mask for each beat. Byte lanes are big-endian: request byte 0 of a doubleword sits on the most significant lane of the selected half of the bus.

A request is taken when `req_valid` is high while `req_ready` is high. From the next cycle the block presents beats. It moves to the next beat only in a cycle where `beat_wait` is low. The final beat is marked by `beat_last`. Multi-beat writes that start on the upper doubleword, or that end on half a beat, get a different mask on the first, middle and last beats.

Requests that cannot be served produce no beats. Instead, one-cycle flags are raised, and the upstream logic uses them to send an error response.

Top module: `rsb_top`

## Requirements
- R1: After reset `req_ready` is 1 and `beat_valid`, `err_unsup`, `err_illegal` and `err_resp` are 0.
- R2: A size code below 1011 yields one beat with burst count 1. The 8-lane mask (bit 7 = request byte 0) is, for word pointer 0 / 1 respectively: 0000: 80/08, 0001: 40/04, 0010: 20/02, 0011: 10/01, 0100: C0/0C, 0101: E0/07, 0110: 30/03, 0111: F8/1F, 1000: F0/0F, 1001: FC/3F, 1010: FE/7F. This mask occupies lanes 7..0 when the doubleword select is 0 and lanes 15..8 when it is 1.
- R3: Size 1011 with word pointer 0 enables the selected doubleword (00FF or FF00). With word pointer 1 and select 0 it gives one beat of FFFF. A write with word pointer 1 and select 1 gives two beats, FF00 then 00FF.
- R4: A read with size 1011, word pointer 1 and select 1, or any read with size 1100..1111 and select 1, raises `err_unsup` and `err_resp` for one cycle and issues no beat.
- R5: A read with size 1100..1111 and select 0 has burst count 4*(size-12)+2+2*wordpointer, with FFFF on every beat.
- R6: A write with size 1100..1111 and select 0 of L doublewords has burst count ceil(L/2). Every beat is FFFF except that the last beat is 00FF when L is odd.
- R7: A write with size 1100..1111 and select 1 of L doublewords has burst count floor(L/2)+1. The first beat is FF00 and the middle beats are FFFF. The last beat is 00FF when L is even and FFFF when L is odd.
- R8: A burst of one beat carries the first-beat mask ANDed with the last-beat mask.
- R9: Non-contiguous or otherwise non-compliant masks (for example sizes 0101, 0111, 1010) are issued unchanged.
- R10: A write length of zero, or longer than allowed, raises `err_illegal` for one cycle and issues no beat. The allowed length is 1 doubleword below size 1011, 2 for size 1011 with word pointer 1, and 8*(size-12)+4+4*wordpointer for sizes 1100..1111. `err_resp` rises with it only when `req_resp` is 1.
- R11: While `beat_wait` is 1 the current beat, its mask and `beat_last` hold. The block advances only in a cycle with `beat_wait` 0.
- R12: `req_ready` is 0 from the cycle after acceptance until the cycle after the final beat is taken. A `req_valid` seen in that window is ignored. `burst_cnt` holds across the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Size code |
| req_wdptr | input | 1 | Word pointer |
| req_dsel | input | 1 | Doubleword select (address bit 0) |
| req_len | input | LEN_W | Write payload length in doublewords |
| req_resp | input | 1 | Write expects a response |
| beat_wait | input | 1 | Downstream stall |
| beat_valid | output | 1 | A beat is presented |
| beat_be | output | 16 | Byte enables of the current beat |
| burst_cnt | output | LEN_W | Burst count of the current request |
| beat_first | output | 1 | Current beat is the first |
| beat_last | output | 1 | Current beat is the final one (done) |
| err_unsup | output | 1 | Unsupported read, one-cycle pulse |
| err_illegal | output | 1 | Illegal write length, one-cycle pulse |
| err_resp | output | 1 | Error response needed, one-cycle pulse |

## Verification
The bench builds the block with the default LEN_W of 6. This holds lengths up to 32 doublewords, the largest legal write, so the 17-beat burst of a 32-doubleword write starting on the upper doubleword is within reach. A 6-bit length also admits lengths above each size limit, so over-length writes can be presented. A stall is applied in the middle of a long burst, and a second request is driven while a burst is running.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    localparam int LANES = 16;
    localparam int HALF  = LANES / 2;

    typedef logic [LANES-1:0] be_t;
    typedef logic [HALF-1:0]  half_t;

    localparam be_t BE_ALL = {LANES{1'b1}};
    localparam be_t BE_LO  = {{HALF{1'b0}}, {HALF{1'b1}}};
    localparam be_t BE_HI  = {{HALF{1'b1}}, {HALF{1'b0}}};

    localparam logic [3:0] SZ_DW = 4'hB;
endpackage

// File: rtl/rsb_size_decode.sv
module rsb_size_decode
    import rsb_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             is_write,
    input  logic [3:0]       size,
    input  logic             wdptr,
    input  logic             dsel,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output be_t              be_first,
    output be_t              be_mid,
    output be_t              be_last,
    output logic             unsup,
    output logic             illegal
);
    half_t            m8;
    be_t              placed;
    logic             big;
    logic [1:0]       slo;
    logic [LEN_W-1:0] rd_beats;
    logic [LEN_W-1:0] max_dw;
    logic [LEN_W:0]   len_p1;

    // byte 0 of the doubleword maps to the top lane of the half
    always_comb begin
        unique case (size)
            4'h0: m8 = wdptr ? 8'h08 : 8'h80;
            4'h1: m8 = wdptr ? 8'h04 : 8'h40;
            4'h2: m8 = wdptr ? 8'h02 : 8'h20;
            4'h3: m8 = wdptr ? 8'h01 : 8'h10;
            4'h4: m8 = wdptr ? 8'h0C : 8'hC0;
            4'h5: m8 = wdptr ? 8'h07 : 8'hE0;
            4'h6: m8 = wdptr ? 8'h03 : 8'h30;
            4'h7: m8 = wdptr ? 8'h1F : 8'hF8;
            4'h8: m8 = wdptr ? 8'h0F : 8'hF0;
            4'h9: m8 = wdptr ? 8'h3F : 8'hFC;
            4'hA: m8 = wdptr ? 8'h7F : 8'hFE;
            default: m8 = 8'hFF;
        endcase
    end

    assign placed   = dsel ? {m8, {HALF{1'b0}}} : {{HALF{1'b0}}, m8};
    assign big      = size[3] & size[2];
    assign slo      = size[1:0];
    assign rd_beats = LEN_W'({slo, 2'b00}) + LEN_W'(2) + LEN_W'({wdptr, 1'b0});
    assign max_dw   = LEN_W'({slo, 3'b000}) + LEN_W'(4) + LEN_W'({wdptr, 2'b00});
    assign len_p1   = {1'b0, len} + (LEN_W+1)'(1);

    always_comb begin
        cnt      = LEN_W'(1);
        be_first = placed;
        be_mid   = placed;
        be_last  = placed;
        unsup    = 1'b0;
        illegal  = 1'b0;
        if (!big) begin
            if (size == SZ_DW && wdptr) begin
                if (!dsel) begin
                    be_first = BE_ALL;
                    be_mid   = BE_ALL;
                    be_last  = BE_ALL;
                end else if (is_write) begin
                    cnt      = LEN_W'(2);
                    be_first = BE_HI;
                    be_mid   = BE_ALL;
                    be_last  = BE_LO;
                end else begin
                    unsup = 1'b1;
                end
            end
            if (is_write)
                illegal = (len == '0) ||
                          (len > ((size == SZ_DW && wdptr) ? LEN_W'(2) : LEN_W'(1)));
        end else if (!is_write) begin
            if (dsel) begin
                unsup = 1'b1;
            end else begin
                cnt      = rd_beats;
                be_first = BE_ALL;
                be_mid   = BE_ALL;
                be_last  = BE_ALL;
            end
        end else begin
            illegal  = (len == '0) || (len > max_dw);
            cnt      = dsel ? LEN_W'(len >> 1) + LEN_W'(1) : LEN_W'(len_p1 >> 1);
            be_first = dsel ? BE_HI : BE_ALL;
            be_mid   = BE_ALL;
            be_last  = (dsel ^ len[0]) ? BE_LO : BE_ALL;
        end
    end
endmodule

// File: rtl/rsb_beat_seq.sv
module rsb_beat_seq
    import rsb_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] ld_cnt,
    input  be_t              ld_first,
    input  be_t              ld_mid,
    input  be_t              ld_last,
    input  logic             ld_unsup,
    input  logic             ld_illegal,
    input  logic             ld_want_resp,
    input  logic             beat_wait,
    output logic             ready,
    output logic             beat_valid,
    output be_t              beat_be,
    output logic [LEN_W-1:0] burst_cnt,
    output logic             beat_first,
    output logic             beat_last,
    output logic             err_unsup,
    output logic             err_illegal,
    output logic             err_resp
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] remain;
        be_t              be_f;
        be_t              be_m;
        be_t              be_l;
        logic             unsup;
        logic             illegal;
        logic             resp;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.unsup   = 1'b0;
        st_d.illegal = 1'b0;
        st_d.resp    = 1'b0;
        if (load) begin
            if (ld_unsup || ld_illegal) begin
                st_d.unsup   = ld_unsup;
                st_d.illegal = ld_illegal;
                st_d.resp    = ld_unsup | (ld_illegal & ld_want_resp);
            end else begin
                st_d.active = 1'b1;
                st_d.cnt    = ld_cnt;
                st_d.remain = ld_cnt;
                st_d.be_f   = ld_first;
                st_d.be_m   = ld_mid;
                st_d.be_l   = ld_last;
            end
        end else if (st_q.active && !beat_wait) begin
            if (st_q.remain == LEN_W'(1))
                st_d.active = 1'b0;
            else
                st_d.remain = st_q.remain - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready       = !st_q.active;
    assign beat_valid  = st_q.active;
    assign burst_cnt   = st_q.cnt;
    assign beat_first  = st_q.active && (st_q.remain == st_q.cnt);
    assign beat_last   = st_q.active && (st_q.remain == LEN_W'(1));
    assign err_unsup   = st_q.unsup;
    assign err_illegal = st_q.illegal;
    assign err_resp    = st_q.resp;

    always_comb begin
        if (!st_q.active)                        beat_be = '0;
        else if (beat_first && beat_last)        beat_be = st_q.be_f & st_q.be_l;
        else if (beat_first)                     beat_be = st_q.be_f;
        else if (beat_last)                      beat_be = st_q.be_l;
        else                                     beat_be = st_q.be_m;
    end

    a_r11_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_wait |=> beat_valid && $stable(beat_be) && $stable(beat_last));
    a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_last && !beat_wait |=> !beat_valid && ready);
    a_r12_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_first |-> $stable(burst_cnt));
    a_r10_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (err_unsup || err_illegal) |-> !beat_valid);
    a_r10_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_resp |-> (err_unsup || err_illegal));
    a_r2_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> beat_be != '0);
endmodule

// File: rtl/rsb_top.sv
module rsb_top
    import rsb_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [3:0]       req_size,
    input  logic             req_wdptr,
    input  logic             req_dsel,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_resp,
    input  logic             beat_wait,
    output logic             beat_valid,
    output logic [15:0]      beat_be,
    output logic [LEN_W-1:0] burst_cnt,
    output logic             beat_first,
    output logic             beat_last,
    output logic             err_unsup,
    output logic             err_illegal,
    output logic             err_resp
);
    logic [LEN_W-1:0] dec_cnt;
    be_t              dec_f, dec_m, dec_l;
    logic             dec_unsup, dec_illegal;
    logic             take;

    assign take = req_valid && req_ready;

    rsb_size_decode #(.LEN_W(LEN_W)) u_dec (
        .is_write (req_write),
        .size     (req_size),
        .wdptr    (req_wdptr),
        .dsel     (req_dsel),
        .len      (req_len),
        .cnt      (dec_cnt),
        .be_first (dec_f),
        .be_mid   (dec_m),
        .be_last  (dec_l),
        .unsup    (dec_unsup),
        .illegal  (dec_illegal)
    );

    rsb_beat_seq #(.LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (take),
        .ld_cnt       (dec_cnt),
        .ld_first     (dec_f),
        .ld_mid       (dec_m),
        .ld_last      (dec_l),
        .ld_unsup     (dec_unsup),
        .ld_illegal   (dec_illegal),
        .ld_want_resp (req_resp),
        .beat_wait    (beat_wait),
        .ready        (req_ready),
        .beat_valid   (beat_valid),
        .beat_be      (beat_be),
        .burst_cnt    (burst_cnt),
        .beat_first   (beat_first),
        .beat_last    (beat_last),
        .err_unsup    (err_unsup),
        .err_illegal  (err_illegal),
        .err_resp     (err_resp)
    );

    a_r4_write_never_unsup: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_write |=> !err_unsup);
    a_r4_read_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        take && !req_write |=> !err_illegal);
    a_r12_first_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !beat_valid || beat_first);
endmodule

// File: tb/tb_rsb_top.sv
module tb_rsb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 6;
    localparam int NV = 25;

    typedef struct packed {
        logic        wr;
        logic [3:0]  sz;
        logic        wd;
        logic        ds;
        logic [5:0]  len;
        logic        rsp;
        logic [3:0]  tag;
        logic [5:0]  cnt;
        logic [15:0] bf;
        logic [15:0] bm;
        logic [15:0] bl;
        logic [2:0]  err;   // {unsup, illegal, resp}
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0,4'h0,1'b0,1'b0,6'd0,1'b0,4'd2,6'd1,16'h0080,16'h0080,16'h0080,3'b000}, // R2
        '{1'b0,4'h0,1'b1,1'b0,6'd0,1'b0,4'd2,6'd1,16'h0008,16'h0008,16'h0008,3'b000}, // R2
        '{1'b0,4'h3,1'b1,1'b1,6'd0,1'b0,4'd2,6'd1,16'h0100,16'h0100,16'h0100,3'b000}, // R2
        '{1'b0,4'h4,1'b0,1'b1,6'd0,1'b0,4'd2,6'd1,16'hC000,16'hC000,16'hC000,3'b000}, // R2
        '{1'b1,4'h6,1'b1,1'b0,6'd1,1'b0,4'd2,6'd1,16'h0003,16'h0003,16'h0003,3'b000}, // R2
        '{1'b0,4'h5,1'b0,1'b0,6'd0,1'b0,4'd9,6'd1,16'h00E0,16'h00E0,16'h00E0,3'b000}, // R9
        '{1'b1,4'h7,1'b1,1'b1,6'd1,1'b0,4'd9,6'd1,16'h1F00,16'h1F00,16'h1F00,3'b000}, // R9
        '{1'b0,4'hA,1'b1,1'b0,6'd0,1'b0,4'd9,6'd1,16'h007F,16'h007F,16'h007F,3'b000}, // R9
        '{1'b0,4'hB,1'b0,1'b1,6'd0,1'b0,4'd3,6'd1,16'hFF00,16'hFF00,16'hFF00,3'b000}, // R3
        '{1'b0,4'hB,1'b1,1'b0,6'd0,1'b0,4'd3,6'd1,16'hFFFF,16'hFFFF,16'hFFFF,3'b000}, // R3
        '{1'b1,4'hB,1'b1,1'b1,6'd2,1'b0,4'd3,6'd2,16'hFF00,16'hFFFF,16'h00FF,3'b000}, // R3
        '{1'b0,4'hB,1'b1,1'b1,6'd0,1'b0,4'd4,6'd0,16'h0000,16'h0000,16'h0000,3'b101}, // R4
        '{1'b0,4'hC,1'b0,1'b0,6'd0,1'b0,4'd5,6'd2,16'hFFFF,16'hFFFF,16'hFFFF,3'b000}, // R5
        '{1'b0,4'hF,1'b1,1'b0,6'd0,1'b0,4'd5,6'd16,16'hFFFF,16'hFFFF,16'hFFFF,3'b000},// R5
        '{1'b0,4'hD,1'b0,1'b1,6'd0,1'b0,4'd4,6'd0,16'h0000,16'h0000,16'h0000,3'b101}, // R4
        '{1'b1,4'hC,1'b0,1'b0,6'd4,1'b0,4'd6,6'd2,16'hFFFF,16'hFFFF,16'hFFFF,3'b000}, // R6
        '{1'b1,4'hD,1'b1,1'b0,6'd5,1'b0,4'd6,6'd3,16'hFFFF,16'hFFFF,16'h00FF,3'b000}, // R6 + busy request
        '{1'b1,4'hC,1'b1,1'b1,6'd4,1'b0,4'd7,6'd3,16'hFF00,16'hFFFF,16'h00FF,3'b000}, // R7
        '{1'b1,4'hC,1'b0,1'b1,6'd3,1'b0,4'd7,6'd2,16'hFF00,16'hFFFF,16'hFFFF,3'b000}, // R7
        '{1'b1,4'hF,1'b1,1'b1,6'd32,1'b0,4'd7,6'd17,16'hFF00,16'hFFFF,16'h00FF,3'b000},// R7 + R11 stall
        '{1'b1,4'hC,1'b0,1'b0,6'd1,1'b0,4'd8,6'd1,16'h00FF,16'h00FF,16'h00FF,3'b000}, // R8
        '{1'b1,4'hC,1'b0,1'b0,6'd5,1'b1,4'd10,6'd0,16'h0000,16'h0000,16'h0000,3'b011},// R10
        '{1'b1,4'h0,1'b0,1'b0,6'd2,1'b0,4'd10,6'd0,16'h0000,16'h0000,16'h0000,3'b010},// R10
        '{1'b1,4'h8,1'b0,1'b1,6'd0,1'b1,4'd10,6'd0,16'h0000,16'h0000,16'h0000,3'b011},// R10
        '{1'b1,4'hD,1'b0,1'b0,6'd3,1'b0,4'd6,6'd2,16'hFFFF,16'hFFFF,16'h00FF,3'b000}  // R6
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [3:0]       req_size = 4'h0;
    logic             req_wdptr = 1'b0;
    logic             req_dsel = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_resp = 1'b0;
    logic             beat_wait = 1'b0;
    logic             beat_valid;
    logic [15:0]      beat_be;
    logic [LEN_W-1:0] burst_cnt;
    logic             beat_first, beat_last;
    logic             err_unsup, err_illegal, err_resp;

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsb_top #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_wdptr(req_wdptr),
        .req_dsel(req_dsel), .req_len(req_len), .req_resp(req_resp),
        .beat_wait(beat_wait), .beat_valid(beat_valid), .beat_be(beat_be),
        .burst_cnt(burst_cnt), .beat_first(beat_first), .beat_last(beat_last),
        .err_unsup(err_unsup), .err_illegal(err_illegal), .err_resp(err_resp)
    );

    task automatic chk(input bit ok, input int r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic run_vec(input int idx, input vec_t v, input int stall_beat,
                           input int stall_n, input bit intrude);
        int r;
        logic [15:0] exp_be;
        r = int'(v.tag);
        @(negedge clk);
        chk(req_ready == 1'b1, 12, $sformatf("v%0d ready before", idx), 32'(req_ready), 32'd1);
        req_write = v.wr; req_size = v.sz; req_wdptr = v.wd; req_dsel = v.ds;
        req_len = v.len; req_resp = v.rsp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.err != 3'b000) begin
            chk({err_unsup, err_illegal, err_resp} == v.err, r, $sformatf("v%0d flags", idx),
                32'({err_unsup, err_illegal, err_resp}), 32'(v.err));
            chk(!beat_valid, r, $sformatf("v%0d no beat", idx), 32'(beat_valid), 32'd0);
            @(negedge clk);
            chk({err_unsup, err_illegal, err_resp} == 3'b000 && req_ready, r,
                $sformatf("v%0d flags pulse", idx),
                32'({req_ready, err_unsup, err_illegal, err_resp}), 32'h8);
        end else begin
            for (int b = 0; b < int'(v.cnt); b++) begin
                if (int'(v.cnt) == 1)            exp_be = v.bf;
                else if (b == 0)                 exp_be = v.bf;
                else if (b == int'(v.cnt) - 1)   exp_be = v.bl;
                else                             exp_be = v.bm;
                chk(beat_valid && beat_be == exp_be, r, $sformatf("v%0d beat %0d be", idx, b),
                    32'({beat_valid, beat_be}), 32'({1'b1, exp_be}));
                chk(burst_cnt == LEN_W'(v.cnt), r, $sformatf("v%0d burst count", idx),
                    32'(burst_cnt), 32'(v.cnt));
                chk(beat_last == (b == int'(v.cnt) - 1), 12, $sformatf("v%0d beat %0d last", idx, b),
                    32'(beat_last), 32'(b == int'(v.cnt) - 1));
                if (b == stall_beat) begin
                    beat_wait = 1'b1;
                    for (int s = 0; s < stall_n; s++) begin
                        @(negedge clk);
                        // R11: beat held while stalled
                        chk(beat_valid && beat_be == exp_be && beat_last == (b == int'(v.cnt) - 1),
                            11, $sformatf("v%0d stall %0d", idx, s),
                            32'({beat_valid, beat_be}), 32'({1'b1, exp_be}));
                    end
                    beat_wait = 1'b0;
                end
                if (intrude && b == 1) begin
                    // R12: request while busy must be ignored
                    req_write = 1'b0; req_size = 4'h0; req_wdptr = 1'b0; req_dsel = 1'b0;
                    req_valid = 1'b1;
                    chk(!req_ready, 12, $sformatf("v%0d busy ready", idx), 32'(req_ready), 32'd0);
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
            chk(!beat_valid && req_ready, 12, $sformatf("v%0d idle after done", idx),
                32'({beat_valid, req_ready}), 32'b01);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL R12 watchdog expired: got %h expected %h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in reset and after release
        chk(!beat_valid && !err_unsup && !err_illegal && !err_resp, 1, "reset outputs",
            32'({beat_valid, err_unsup, err_illegal, err_resp}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !beat_valid, 1, "ready after reset",
            32'({req_ready, beat_valid}), 32'b10);

        for (int i = 0; i < NV; i++)
            run_vec(i, VECS[i], (i == 19) ? 5 : -1, 3, (i == 16));

        // R11: stall on the very first and last beats of a two-beat write
        run_vec(100, VECS[10], 0, 2, 1'b0);
        run_vec(101, VECS[10], 1, 4, 1'b0);
        // R12: nothing starts after an ignored busy request
        @(negedge clk);
        chk(!beat_valid && !err_unsup, 12, "no late start", 32'(beat_valid), 32'd0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule